// File: doc/BRIEF.md
# Interrupt Source Masking and Routing

This block gathers a vector of level-sensitive hardware interrupt request lines and a software request register into one set of raw requests. A select register steers each source to either the normal interrupt output or the fast interrupt output. The normal path is gated by a per-source enable. The fast path is not gated by the enable. The normal output is also qualified by a priority mask. A neighbouring vector unit drives that mask for the current priority level.

Software reaches the block through a simple word-addressed register bus. Writes take effect at the clock edge. Reads are combinational and have no side effects. The enable register and the software request register cannot be written directly. Each one has a write-one-to-set word and a write-one-to-clear word, so a driver can change a single bit without a read-modify-write. Three views of the sources can be read: raw requests, normal-class status and fast-class status.

Top module: `intr_steer`

## Requirements
- R1: After reset every register reads zero, both outputs are low, and every status view reads zero while the hardware lines are low.
- R2: Word offset 2 reads the raw requests. A raw request is the hardware line OR the software request bit. A hardware line reaches the views one clock after it is sampled.
- R3: A write to word offset 4 ORs the data into the enable register. A write to word offset 5 clears each enable bit where the data holds a one. Offset 4 reads the enable register back.
- R4: A write to word offset 6 ORs the data into the software request register. A write to word offset 7 clears each software request bit where the data holds a one. Offset 6 reads the software request register back.
- R5: A write to word offset 3 loads the whole fast-select register, and offset 3 reads it back. A bit value of 1 sends that source to the fast class.
- R6: Word offset 0 reads the normal-class status, which is raw AND enable AND NOT fast-select.
- R7: Word offset 1 reads the fast-class status, which is raw AND fast-select regardless of the enable. No source is ever set in both status views.
- R8: fiq_out is high exactly when the fast-class status held any set bit in the previous cycle.
- R9: irq_out is high exactly when, in the previous cycle, some normal-class status bit was also set in prio_mask.
- R10: Writes to word offsets 0, 1 and 2 are ignored and leave every register unchanged.
- R11: Word offset 8 holds a single guard bit taken from bit 0 of the write data. Its read returns that bit with every upper bit zero.
- R12: Writes to word offsets 9 to 15 have no effect. Reads of offsets 5, 7 and 9 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | N_SRC | Level-sensitive hardware request lines |
| prio_mask | input | N_SRC | Sources allowed to raise irq_out at the current priority level |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Combinational read data for bus_addr |
| irq_out | output | 1 | Registered normal interrupt output |
| fiq_out | output | 1 | Registered fast interrupt output |

## Verification
On every cycle, the assertions check the following:
- both output lines against the previous cycle's raw, enable, select and mask state;
- that no source appears in both classes;
- the set, clear and load effect of each register write;
- that writes to the status words leave all state unchanged;
- that the guard read has its upper bits zero.

The bench scenarios are needed for the rest. They show that the read views and the register reads return the right words for every combination of hardware, software, enable and select on each bit. They also show the exact one-cycle latency from a hardware line change or a register write to the outputs, and that unmapped offsets read zero and ignore writes.

// File: rtl/intr_steer_pkg.sv
package intr_steer_pkg;

    localparam int OFS_IRQ_STAT = 0;
    localparam int OFS_FIQ_STAT = 1;
    localparam int OFS_RAW      = 2;
    localparam int OFS_FAST_SEL = 3;
    localparam int OFS_EN_SET   = 4;
    localparam int OFS_EN_CLR   = 5;
    localparam int OFS_SW_SET   = 6;
    localparam int OFS_SW_CLR   = 7;
    localparam int OFS_GUARD    = 8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_FAST_SEL,
        ACC_EN_SET,
        ACC_EN_CLR,
        ACC_SW_SET,
        ACC_SW_CLR,
        ACC_GUARD
    } wr_kind_e;

endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] d,
    output logic [N_SRC-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/intr_regs.sv
module intr_regs
    import intr_steer_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  en_q,
    output logic [N_SRC-1:0]  sw_q,
    output logic [N_SRC-1:0]  sel_q,
    output logic              guard_q
);

    wr_kind_e kind;

    always_comb begin
        kind = ACC_NONE;
        if (bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(OFS_FAST_SEL): kind = ACC_FAST_SEL;
                ADDR_W'(OFS_EN_SET):   kind = ACC_EN_SET;
                ADDR_W'(OFS_EN_CLR):   kind = ACC_EN_CLR;
                ADDR_W'(OFS_SW_SET):   kind = ACC_SW_SET;
                ADDR_W'(OFS_SW_CLR):   kind = ACC_SW_CLR;
                ADDR_W'(OFS_GUARD):    kind = ACC_GUARD;
                default:               kind = ACC_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            sw_q    <= '0;
            sel_q   <= '0;
            guard_q <= 1'b0;
        end else begin
            unique case (kind)
                ACC_FAST_SEL: sel_q   <= bus_wdata;
                ACC_EN_SET:   en_q    <= en_q | bus_wdata;
                ACC_EN_CLR:   en_q    <= en_q & ~bus_wdata;
                ACC_SW_SET:   sw_q    <= sw_q | bus_wdata;
                ACC_SW_CLR:   sw_q    <= sw_q & ~bus_wdata;
                ACC_GUARD:    guard_q <= bus_wdata[0];
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/intr_route.sv
module intr_route #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hw_q,
    input  logic [N_SRC-1:0] en_q,
    input  logic [N_SRC-1:0] sw_q,
    input  logic [N_SRC-1:0] sel_q,
    input  logic [N_SRC-1:0] prio_mask,
    output logic [N_SRC-1:0] raw,
    output logic [N_SRC-1:0] irq_stat,
    output logic [N_SRC-1:0] fiq_stat,
    output logic             irq_out,
    output logic             fiq_out
);

    logic [N_SRC-1:0] irq_hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign raw[i]      = hw_q[i] | sw_q[i];
        assign irq_stat[i] = raw[i] & en_q[i] & ~sel_q[i];
        assign fiq_stat[i] = raw[i] & sel_q[i];
        assign irq_hit[i]  = irq_stat[i] & prio_mask[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
            fiq_out <= 1'b0;
        end else begin
            irq_out <= |irq_hit;
            fiq_out <= |fiq_stat;
        end
    end

endmodule

// File: rtl/intr_rdmux.sv
module intr_rdmux
    import intr_steer_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  irq_stat,
    input  logic [N_SRC-1:0]  fiq_stat,
    input  logic [N_SRC-1:0]  raw,
    input  logic [N_SRC-1:0]  sel_q,
    input  logic [N_SRC-1:0]  en_q,
    input  logic [N_SRC-1:0]  sw_q,
    input  logic              guard_q,
    output logic [N_SRC-1:0]  bus_rdata
);

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_IRQ_STAT): bus_rdata = irq_stat;
            ADDR_W'(OFS_FIQ_STAT): bus_rdata = fiq_stat;
            ADDR_W'(OFS_RAW):      bus_rdata = raw;
            ADDR_W'(OFS_FAST_SEL): bus_rdata = sel_q;
            ADDR_W'(OFS_EN_SET):   bus_rdata = en_q;
            ADDR_W'(OFS_SW_SET):   bus_rdata = sw_q;
            ADDR_W'(OFS_GUARD):    bus_rdata = {{(N_SRC-1){1'b0}}, guard_q};
            default:               bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intr_steer.sv
module intr_steer #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  hw_req,
    input  logic [N_SRC-1:0]  prio_mask,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              irq_out,
    output logic              fiq_out
);

    logic [N_SRC-1:0] hw_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] sw_q;
    logic [N_SRC-1:0] sel_q;
    logic             guard_q;
    logic [N_SRC-1:0] raw;
    logic [N_SRC-1:0] irq_stat;
    logic [N_SRC-1:0] fiq_stat;

    intr_sync #(.N_SRC(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hw_req),
        .q     (hw_q)
    );

    intr_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_q      (en_q),
        .sw_q      (sw_q),
        .sel_q     (sel_q),
        .guard_q   (guard_q)
    );

    intr_route #(.N_SRC(N_SRC)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_q      (hw_q),
        .en_q      (en_q),
        .sw_q      (sw_q),
        .sel_q     (sel_q),
        .prio_mask (prio_mask),
        .raw       (raw),
        .irq_stat  (irq_stat),
        .fiq_stat  (fiq_stat),
        .irq_out   (irq_out),
        .fiq_out   (fiq_out)
    );

    intr_rdmux #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_rdmux (
        .bus_addr  (bus_addr),
        .irq_stat  (irq_stat),
        .fiq_stat  (fiq_stat),
        .raw       (raw),
        .sel_q     (sel_q),
        .en_q      (en_q),
        .sw_q      (sw_q),
        .guard_q   (guard_q),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/intr_steer_chk.sv
module intr_steer_chk #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_SRC-1:0]  bus_wdata,
    input logic [N_SRC-1:0]  bus_rdata,
    input logic [N_SRC-1:0]  prio_mask,
    input logic              irq_out,
    input logic              fiq_out,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  sw_q,
    input logic [N_SRC-1:0]  sel_q,
    input logic              guard_q,
    input logic [N_SRC-1:0]  raw,
    input logic [N_SRC-1:0]  irq_stat,
    input logic [N_SRC-1:0]  fiq_stat
);

    // R8: fast output follows last cycle's fast-class raw requests
    assert_fiq_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_out == $past(|(raw & sel_q)));

    // R9: normal output follows last cycle's enabled, unselected, masked requests
    assert_irq_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(raw & en_q & ~sel_q & prio_mask)));

    // R7: a source is never in both classes
    assert_one_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat & fiq_stat) == '0);

    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(5)) |=> ((en_q & $past(bus_wdata)) == '0));

    assert_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(6)) |=> ((sw_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_sw_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(7)) |=> ((sw_q & $past(bus_wdata)) == '0));

    assert_sel_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(3)) |=> (sel_q == $past(bus_wdata)));

    assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr <= ADDR_W'(2)) |=>
            ($stable(en_q) && $stable(sw_q) && $stable(sel_q) && $stable(guard_q)));

    assert_guard_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(8)) |-> (bus_rdata[N_SRC-1:1] == '0));

endmodule

bind intr_steer intr_steer_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .prio_mask (prio_mask),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .en_q      (en_q),
    .sw_q      (sw_q),
    .sel_q     (sel_q),
    .guard_q   (guard_q),
    .raw       (raw),
    .irq_stat  (irq_stat),
    .fiq_stat  (fiq_stat)
);

// File: tb/intr_steer_bench.sv
`timescale 1ns/1ps
module intr_steer_bench;

    localparam int N  = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  hw_req;
    logic [N-1:0]  prio_mask;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [N-1:0]  bus_wdata;
    logic [N-1:0]  bus_rdata;
    logic          irq_out;
    logic          fiq_out;

    int vec_cnt = 0;
    int bad_cnt = 0;

    logic [N-1:0] m_hw, m_en, m_sw, m_sel;
    logic         m_guard;

    always #2.5 clk = ~clk;

    intr_steer #(.N_SRC(N), .ADDR_W(AW)) u_intr_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_req    (hw_req),
        .prio_mask (prio_mask),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .fiq_out   (fiq_out)
    );

    function automatic logic [N-1:0] x_raw();
        return m_hw | m_sw;
    endfunction
    function automatic logic [N-1:0] x_irq();
        return x_raw() & m_en & ~m_sel;
    endfunction
    function automatic logic [N-1:0] x_fiq();
        return x_raw() & m_sel;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = AW'(a);
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [N-1:0] v);
        bus_addr = AW'(a);
        #0.5;
        v = bus_rdata;
    endtask

    task automatic check_all(input string ctx);
        logic [N-1:0] v;
        @(negedge clk);
        @(negedge clk);
        rd(0, v); chk({"R6 irq status ", ctx}, 32'(v), 32'(x_irq()));
        rd(1, v); chk({"R7 fiq status ", ctx}, 32'(v), 32'(x_fiq()));
        rd(2, v); chk({"R2 raw ", ctx}, 32'(v), 32'(x_raw()));
        rd(3, v); chk({"R5 select ", ctx}, 32'(v), 32'(m_sel));
        rd(4, v); chk({"R3 enable ", ctx}, 32'(v), 32'(m_en));
        rd(6, v); chk({"R4 soft ", ctx}, 32'(v), 32'(m_sw));
        rd(8, v); chk({"R11 guard ", ctx}, 32'(v), {31'b0, m_guard});
        chk({"R8 fiq_out ", ctx}, 32'(fiq_out), 32'(|x_fiq()));
        chk({"R9 irq_out ", ctx}, 32'(irq_out), 32'(|(x_irq() & prio_mask)));
    endtask

    task automatic apply(input logic [N-1:0] hw, input logic [N-1:0] en,
                         input logic [N-1:0] sw, input logic [N-1:0] sel,
                         input logic [N-1:0] pm);
        @(negedge clk);
        hw_req = hw; prio_mask = pm;
        m_hw = hw;
        wr(5, '1); wr(4, en); m_en = en;
        wr(7, '1); wr(6, sw); m_sw = sw;
        wr(3, sel); m_sel = sel;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        rst_n = 1'b0; hw_req = '0; prio_mask = '1;
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        m_hw = '0; m_en = '0; m_sw = '0; m_sel = '0; m_guard = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1 reset");

        // R3: set accumulates, clear removes only written ones
        wr(4, 8'h0F); wr(4, 8'h30); rd(4, v);
        chk("R3 set accumulate", 32'(v), 32'h3F);
        wr(5, 8'h05); rd(4, v);
        chk("R3 clear", 32'(v), 32'h3A);
        m_en = 8'h3A;
        // R4: same for software requests
        wr(6, 8'h81); wr(6, 8'h42); rd(6, v);
        chk("R4 set accumulate", 32'(v), 32'hC3);
        wr(7, 8'h80); rd(6, v);
        chk("R4 clear", 32'(v), 32'h43);
        m_sw = 8'h43;
        check_all("R3 R4 directed");

        // R11: only bit 0 of the guard is stored
        wr(8, 8'hFE); rd(8, v); chk("R11 guard even", 32'(v), 32'h0);
        wr(8, 8'hFF); rd(8, v); chk("R11 guard odd", 32'(v), 32'h1);
        m_guard = 1'b1;

        // R8 latency: select a raised source, output moves one cycle later
        apply(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);
        check_all("R8 prep");
        wr(6, 8'h10); m_sw = 8'h10;
        wr(3, 8'h10); m_sel = 8'h10;
        chk("R8 fiq_out before edge", 32'(fiq_out), 32'h0);
        @(negedge clk);
        chk("R8 fiq_out after edge", 32'(fiq_out), 32'h1);

        // R2/R9 latency: hardware line goes through one sampling register
        apply(8'h00, 8'h02, 8'h00, 8'h00, 8'hFF);
        check_all("R9 prep");
        @(negedge clk);
        hw_req = 8'h02; m_hw = 8'h02;
        @(negedge clk);
        rd(2, v); chk("R2 raw one cycle after line", 32'(v), 32'h02);
        chk("R9 irq_out still low", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R9 irq_out raised", 32'(irq_out), 32'h1);

        // R10: writes to status words leave state unchanged
        apply(8'h3C, 8'h5A, 8'h81, 8'h24, 8'hFF);
        wr(0, 8'hFF); wr(1, 8'h00); wr(2, 8'hFF);
        check_all("R10 ro writes");

        // R12: unmapped writes ignored and unmapped reads zero
        for (int a = 9; a < 16; a++) wr(a, 8'hFF);
        check_all("R12 unmapped writes");
        rd(5, v); chk("R12 read 5", 32'(v), 32'h0);
        rd(7, v); chk("R12 read 7", 32'(v), 32'h0);
        for (int a = 9; a < 16; a++) begin
            rd(a, v); chk("R12 read unmapped", 32'(v), 32'h0);
        end

        // R6 R7 R8 R9: per-bit truth table over hw, soft, enable, select
        for (int b = 0; b < N; b++) begin
            for (int c = 0; c < 16; c++) begin
                logic [N-1:0] one;
                logic [N-1:0] pm;
                one = N'(1) << b;
                pm  = (b % 2 == 1) ? one : ~one;
                apply(c[0] ? one : '0, c[2] ? one : '0, c[1] ? one : '0, c[3] ? one : '0, pm);
                check_all("truth table");
            end
        end

        // arithmetic sweep of mixed patterns
        for (int k = 0; k < 96; k++) begin
            apply(N'(k * 29 + 3), N'(k * 53 + 17), N'((k * 11) ^ 8'h5A),
                  N'(k * 7 + (k >> 3)), N'(k * 97 + 1));
            check_all("sweep");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule